// File: doc/BRIEF.md
# Chained Plane Hit Capture and Monitor Selector

This block is the digital core of a readout node for a single detector plane. It watches a bus of strip hit inputs. When a trigger strobe arrives and the node is not sending, it freezes a snapshot into one 48-bit record. The record holds, from most significant bit down, a 6-bit board number, a 4-bit tag field, the 6-bit monitor channel in use at that moment, and the 32 strip bits. Up to sixteen such nodes share one serial chain. A controller drives a common 4-bit node address, a mode line, a step strobe and the serial data that flows from node to node.

When the mode line selects event readout and the address equals the node's strapped number, each step strobe (one system-clock cycle per chain clock) moves the next record bit, MSB first, into the registered serial output. All other steps copy the upstream serial input to the serial output, so the chain reads as one continuous stream. In monitor mode the node does not shift. The first addressed step arms monitoring, and each later addressed step moves a 6-bit channel pointer. That pointer picks one strip and routes it to the monitor output. A separate clear line returns the pointer to channel 0 and disarms the selector.

Top module: `chain_node`

## Requirements
- R1: After reset the serial output and the monitor output are 0, monitoring is disarmed and the pointer is 0. Until the first trigger, addressed event steps pass the serial input through.
- R2: A trigger while idle stores the record {board[5:0], tag[3:0], pointer[5:0], strips[31:0]}, with board at bits 47:42 and strips at bits 31:0.
- R3: Strip, board and tag inputs are sampled only at the trigger, so later changes do not alter the stored record.
- R4: With mode = 1 (event) and address = node number, step k (k = 1..48) places record bit 48-k on the serial output after that step.
- R5: Any step that is not shifting the record (wrong address, monitor mode, or all 48 bits already sent) sets the serial output to the serial input sampled at that step.
- R6: A trigger that arrives after the first and before the 48th bit of a readout is ignored. The readout goes on with the old record, and afterwards the node passes data through.
- R7: With mode = 0 (monitor), an addressed step arms a disarmed node without moving the pointer, and advances the pointer by one on an armed node. A monitor-mode step with another address disarms it. While armed, the monitor output equals the strip selected by the pointer; while disarmed it is 0.
- R8: The clear line sets the pointer to 0 and disarms monitoring in the following cycle.
- R9: Pointer values 32 to 63 give a monitor output of 0. The pointer wraps from 63 to 0.
- R10: The pointer field of the record holds the pointer value at the trigger.
- R11: Without a step strobe the serial output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strip_i | input | 32 | Strip hit levels |
| board_i | input | 6 | Board number recorded in each snapshot |
| tag_i | input | 4 | Tag field recorded in each snapshot |
| node_num_i | input | 4 | Strapped position of this node on the chain |
| trig_i | input | 1 | Trigger strobe, one cycle |
| addr_i | input | 4 | Node address driven by the chain controller |
| mode_i | input | 1 | 1 = event readout, 0 = monitor selection |
| step_i | input | 1 | Chain clock strobe, one cycle per chain bit |
| mon_clr_i | input | 1 | Monitor pointer clear |
| ser_i | input | 1 | Serial data from the upstream node |
| ser_o | output | 1 | Registered serial data to the downstream node |
| mon_o | output | 1 | Strip chosen for rate monitoring |

## Verification
A wrong bit counter or a wrong shift register shows up on the serial output at the step where the first bad bit leaves the node. A word that is too short or too long then turns into pass-through data one step early or late. If the capture logic accepts a trigger in the middle of a readout, the remaining record bits change at once. A pointer that is off by one shows on the monitor output in the cycle after the step that moved it. A wrong armed state shows as a monitor output of 0 where a strip level was due, or the reverse. The pointer field in the next record read out exposes the same fault.

// File: rtl/chain_node_pkg.sv
package chain_node_pkg;
    typedef enum logic {
        MODE_MON = 1'b0,
        MODE_EVT = 1'b1
    } chain_mode_e;

    localparam int STRIP_N = 32;
    localparam int BOARD_W = 6;
    localparam int TAG_W   = 4;
    localparam int PTR_W   = 6;
    localparam int ADDR_W  = 4;
endpackage

// File: rtl/chain_shifter.sv
module chain_shifter #(
    parameter int WORD_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              step_i,
    input  logic              go_i,
    input  logic              ser_i,
    output logic              ser_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              so;
    } shf_t;

    shf_t st_d, st_q;
    logic busy, cap;

    assign busy = (st_q.cnt != '0) && (st_q.cnt != FULL);
    assign cap  = trig_i && !busy;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.sh  = word_i;
            st_d.cnt = '0;
            if (step_i) st_d.so = ser_i;
        end else if (step_i) begin
            if (go_i && st_q.cnt != FULL) begin
                st_d.so  = st_q.sh[WORD_W-1];
                st_d.sh  = {st_q.sh[WORD_W-2:0], 1'b0};
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.so = ser_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '0;
            st_q.cnt <= FULL;
            st_q.so  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.so;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
    assert_shift_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && go_i && !trig_i && st_q.cnt != FULL |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !go_i |=> ser_o == $past(ser_i));
    assert_trig_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i && busy && !step_i |=> $stable(st_q.sh) && $stable(st_q.cnt));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(ser_o));
endmodule

// File: rtl/mon_selector.sv
module mon_selector #(
    parameter int STRIPS = 32,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              mon_mode_i,
    input  logic              hit_i,
    input  logic              clr_i,
    input  logic [STRIPS-1:0] strip_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              mon_o
);
    localparam int NSRC = 1 << PTR_W;
    localparam logic [PTR_W:0] LIM = (PTR_W + 1)'(STRIPS);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             en;
    } mon_t;

    mon_t st_d, st_q;
    logic [NSRC-1:0] src;

    generate
        if (NSRC > STRIPS) begin : g_pad
            assign src = {{(NSRC - STRIPS){1'b0}}, strip_i};
        end else begin : g_cut
            assign src = strip_i[NSRC-1:0];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.ptr = '0;
            st_d.en  = 1'b0;
        end else if (step_i && mon_mode_i) begin
            if (hit_i) begin
                if (!st_q.en) st_d.en  = 1'b1;
                else          st_d.ptr = st_q.ptr + 1'b1;
            end else begin
                st_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= '0;
            st_q.en  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;
    assign mon_o = st_q.en & src[st_q.ptr];

    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && mon_mode_i && hit_i && st_q.en && !clr_i |=> st_q.ptr == $past(st_q.ptr) + 1'b1);
    assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && mon_mode_i && hit_i && !st_q.en && !clr_i |=> st_q.en && $stable(st_q.ptr));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.ptr == '0 && !st_q.en);
    assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.ptr} >= LIM |-> !mon_o);
endmodule

// File: rtl/chain_node.sv
module chain_node
    import chain_node_pkg::*;
#(
    parameter int STRIPS = STRIP_N,
    parameter int BRD_W  = BOARD_W,
    parameter int TG_W   = TAG_W,
    parameter int P_W    = PTR_W,
    parameter int A_W    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STRIPS-1:0] strip_i,
    input  logic [BRD_W-1:0]  board_i,
    input  logic [TG_W-1:0]   tag_i,
    input  logic [A_W-1:0]    node_num_i,
    input  logic              trig_i,
    input  logic [A_W-1:0]    addr_i,
    input  logic              mode_i,
    input  logic              step_i,
    input  logic              mon_clr_i,
    input  logic              ser_i,
    output logic              ser_o,
    output logic              mon_o
);
    localparam int WORD_W = BRD_W + TG_W + P_W + STRIPS;

    chain_mode_e      mode;
    logic             hit;
    logic [P_W-1:0]   ptr;
    logic [WORD_W-1:0] word;

    assign mode = chain_mode_e'(mode_i);
    assign hit  = (addr_i == node_num_i);
    assign word = {board_i, tag_i, ptr, strip_i};

    chain_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .word_i (word),
        .step_i (step_i),
        .go_i   (hit && mode == MODE_EVT),
        .ser_i  (ser_i),
        .ser_o  (ser_o)
    );

    mon_selector #(.STRIPS(STRIPS), .PTR_W(P_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step_i),
        .mon_mode_i (mode == MODE_MON),
        .hit_i      (hit),
        .clr_i      (mon_clr_i),
        .strip_i    (strip_i),
        .ptr_o      (ptr),
        .mon_o      (mon_o)
    );
endmodule

// File: tb/sim_chain_node.sv
module sim_chain_node;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [31:0] strip = '0;
    logic [5:0]  board = 6'h2D;
    logic [3:0]  tag   = 4'h9;
    logic [3:0]  node  = 4'd5;
    logic        trig = 0, mode = 1, step = 0, clr = 0, sin = 0;
    logic [3:0]  addr = 4'd0;
    logic        sout, mon;

    chain_node u0 (
        .clk(clk), .rst_n(rst_n), .strip_i(strip), .board_i(board), .tag_i(tag),
        .node_num_i(node), .trig_i(trig), .addr_i(addr), .mode_i(mode),
        .step_i(step), .mon_clr_i(clr), .ser_i(sin), .ser_o(sout), .mon_o(mon)
    );

    int total = 0, bad = 0;
    bit    exp_q[$];
    string tag_q[$];
    logic  pend = 1'b0;
    logic [5:0] mptr = '0;
    logic       men  = 1'b0;
    int         seed = 0;

    // scoreboard monitor: one expected serial bit per step
    always @(posedge clk) pend <= step;
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (sout !== e) begin
                bad++;
                $display("FAIL %s ser_o act=%0b exp=%0b", t, sout, e);
            end
        end
    end

    task automatic chk(input string t, input logic act, input logic e);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", t, act, e);
        end
    endtask

    task automatic cstep(input logic din, input logic e, input string t);
        @(negedge clk);
        sin = din; step = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        step = 1'b0;
    endtask

    function automatic logic nextbit();
        seed = seed + 1;
        return logic'(((seed * 7) >> 1) & 1);
    endfunction

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic read_word(input logic [47:0] w, input string t);
        addr = node; mode = 1'b1;
        for (int i = 47; i >= 0; i--) cstep(nextbit(), w[i], t);
    endtask

    task automatic pass_steps(input int n, input string t);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = nextbit();
            cstep(b, b, t);
        end
    endtask

    task automatic mstep(input logic [3:0] a, input string t);
        logic b;
        mode = 1'b0; addr = a;
        b = nextbit();
        cstep(b, b, "R5 monitor-mode pass");
        if (a == node) begin
            if (!men) men = 1'b1;
            else      mptr = mptr + 1'b1;
        end else begin
            men = 1'b0;
        end
        chk(t, mon, (men && mptr < 6'd32) ? strip[mptr[4:0]] : 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] sa, sb;
        logic [47:0] w;
        repeat (3) @(negedge clk);
        chk("R1 reset ser_o", sout, 1'b0);
        chk("R1 reset mon_o", mon, 1'b0);
        rst_n = 1'b1;
        // R1: no record yet, addressed event steps pass through
        addr = node; mode = 1'b1;
        pass_steps(4, "R1 pass before trigger");

        // R2/R3: capture then change inputs before readout
        sa = 32'hC3A5_0F96; strip = sa;
        pulse_trig();
        strip = 32'h1234_5678; board = 6'h11; tag = 4'h2;
        w = {6'h2D, 4'h9, 6'd0, sa};
        read_word(w, "R2 R3 R4 record bits");
        pass_steps(5, "R5 pass after record");

        // R5: other address while a record is pending
        sb = 32'h8001_F00D; strip = sb; board = 6'h3E; tag = 4'h6;
        pulse_trig();
        addr = 4'd3; mode = 1'b1;
        pass_steps(10, "R5 other address");

        // R6: trigger mid-readout ignored
        w = {6'h3E, 4'h6, 6'd0, sb};
        addr = node; mode = 1'b1;
        for (int i = 47; i >= 0; i--) begin
            cstep(nextbit(), w[i], "R6 record kept");
            if (i == 40) begin
                strip = 32'hFFFF_0000; board = 6'h01;
                pulse_trig();
            end
        end
        pass_steps(3, "R6 pass after record");

        // R7: monitor selection
        strip = 32'hA5C3_96F1;
        chk("R7 disarmed", mon, 1'b0);
        for (int i = 0; i < 5; i++) mstep(node, "R7 select");
        mstep(4'd3, "R7 disarm on other address");
        mstep(node, "R7 rearm keeps pointer");
        mstep(node, "R7 advance");

        // R10: pointer in record
        board = 6'h15; tag = 4'hC;
        pulse_trig();
        w = {6'h15, 4'hC, mptr, strip};
        read_word(w, "R10 pointer field");

        // R8: clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        mptr = '0; men = 1'b0;
        chk("R8 clear output", mon, 1'b0);
        mstep(node, "R8 arm after clear at channel 0");

        // R9: out-of-range channels and wrap
        for (int i = 0; i < 64; i++) mstep(node, "R9 range and wrap");
        chk("R9 wrapped to zero", logic'(mptr == 6'd0), 1'b1);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule